// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into an asynchronous serial frame. Software or a neighbouring block writes a character into a single holding slot. When the shift sequencer is free, the character moves into it and goes out on the serial line. The frame has a start bit of logic 0, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then one, one-and-a-half or two stop bits at logic 1. Between frames the line rests at logic 1.

The frame format comes from a small set of control inputs: character length, stop select, parity on/off, parity sense and forced ("stick") parity. The sequencer captures these when a character enters the shifter, so a change in the middle of a frame only affects the next character. A break input holds the line at logic 0 while the sequencer keeps counting. Software can therefore use the running transmitter as a timer to measure how long the break lasts.

Bit timing comes from a one-cycle enable pulse at sixteen times the baud rate. Two flags report progress. The first shows that the holding slot is free. The second shows that the slot and the shifter are both empty.

Top module: `sertx_top`

## Requirements
- R1: `len_sel` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits follow a single start bit of 0 and go out least significant bit first. Written bits above the selected length are never sent.
- R2: Every start, data and parity bit lasts exactly 16 `baud_tick` pulses. A character in the holding slot enters the shifter on the first `baud_tick` that finds the shifter idle, and the start bit begins at that tick.
- R3: The stop period is 16 ticks when `stop_sel` is 0, 24 ticks when `stop_sel` is 1 with a 5-bit length, and 32 ticks when `stop_sel` is 1 with a 6-, 7- or 8-bit length. The line is 1 throughout the stop period.
- R4: When `par_en` is 1, one parity bit goes between the last data bit and the stop period. With `par_even` at 1, the data bits plus the parity bit hold an even number of ones. With `par_even` at 0, they hold an odd number.
- R5: When `par_en` and `par_stick` are both 1, the parity bit is the inverse of `par_even`, whatever the data.
- R6: While `brk` is 1, `txd` is 0. The sequencer keeps running: `tx_idle` rises at the same tick it would reach without break. `txd` goes back to the normal line value when `brk` clears.
- R7: `hold_empty` goes low on the clock after a write. It goes high again on the clock edge of the tick at which the character moves into the shifter.
- R8: `tx_idle` is 1 only when the holding slot and the shifter are both empty. If a character is waiting when the stop period ends, its start bit begins one tick after the stop period ends.
- R9: After a synchronous reset, `txd` is 1, `hold_empty` is 1 and `tx_idle` is 1.
- R10: The frame format is captured when a character enters the shifter. Changing the control inputs later does not alter that character's frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_tick | input | 1 | One-cycle enable at 16x the bit rate |
| wr_en | input | 1 | Write strobe for the holding slot |
| wr_data | input | 8 | Character to send |
| len_sel | input | 2 | Character length code (R1) |
| stop_sel | input | 1 | Stop length select (R3) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Parity sense, 1 = even |
| par_stick | input | 1 | Forced parity |
| brk | input | 1 | Hold the line at 0 |
| txd | output | 1 | Serial output |
| hold_empty | output | 1 | Holding slot free |
| tx_idle | output | 1 | Holding slot and shifter both empty |

## Verification
The hardest case to reach from the ports is the hand-over between two back-to-back characters. The second character has to sit in the holding slot for the whole of the first frame, and then appear exactly one tick after the stop period ends. The driver writes the second character on the tick right after the first one is loaded. The scoreboard monitor then measures the distance from the end of each frame to the next start bit. Break is harder still, because the line then shows nothing. That test turns the line monitor off and times the frame by counting ticks until `tx_idle` rises.

// File: rtl/sertx_pkg.sv
// Shared types for the serial transmitter.
// Assumes a frame is one start bit, 5..8 data bits, optional parity and a stop period.
package sertx_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_DATA,
        SQ_PAR,
        SQ_STOP
    } sq_state_t;

    typedef struct packed {
        logic [1:0] len;       // 0..3 -> 5..8 data bits
        logic       stop_long; // longer stop period
        logic       par_on;    // parity bit present
        logic       par_even;  // parity sense
        logic       par_stick; // forced parity level
    } frame_cfg_t;

endpackage

// File: rtl/sertx_hold.sv
// One-entry holding slot for the transmitter.
// Assumes that a write while full replaces the waiting character, and that a
// write in the cycle of a load refills the slot.
module sertx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_i,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_empty
);

    logic full;

    // Occupancy: set by a write, cleared when the sequencer takes the character.
    always_ff @(posedge clk) begin
        if (!rst_n) full <= 1'b0;
        else        full <= wr_en | (full & ~load_i);
    end

    // Data capture on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)     hold_data <= '0;
        else if (wr_en) hold_data <= wr_data;
    end

    assign hold_empty = ~full;

    AST_HOLD_RISE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_empty) |-> $past(load_i)); // R7
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !hold_empty); // R7

endmodule

// File: rtl/sertx_seq.sv
// Frame sequencer: takes a character from the holding slot, captures the frame
// format, and steps through start, data, parity and stop on baud ticks.
// Assumes tick_i is a single-cycle pulse at OVS times the bit rate.
module sertx_seq
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              hold_full_i,
    input  logic [DATA_W-1:0] hold_data_i,
    input  frame_cfg_t        cfg_i,
    output logic              load_o,
    output logic              line_o,
    output logic              idle_o
);

    localparam int MIN_BITS = DATA_W - 3;
    localparam int STOP_ONE = OVS;
    localparam int STOP_MID = OVS + OVS / 2;
    localparam int STOP_TWO = 2 * OVS;
    localparam int CW       = $clog2(STOP_TWO);
    localparam int IW       = $clog2(DATA_W);
    localparam logic [CW-1:0] BIT_LAST = CW'(OVS - 1);

    sq_state_t         state;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     stop_last;
    logic [CW-1:0]     lim;
    logic [IW-1:0]     idx;
    logic [IW-1:0]     last_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_on;
    logic              par_bit;
    logic [DATA_W-1:0] len_mask;
    logic              ones_odd;
    logic              par_calc;

    // Take a waiting character only on a tick with the shifter free.
    assign load_o = tick_i & hold_full_i & (state == SQ_IDLE);
    assign idle_o = (state == SQ_IDLE);

    // Parity of the character as it will be framed.
    always_comb begin
        len_mask = ~({DATA_W{1'b1}} << (MIN_BITS + int'(cfg_i.len)));
        ones_odd = ^(hold_data_i & len_mask);
        if (cfg_i.par_stick)     par_calc = ~cfg_i.par_even;
        else if (cfg_i.par_even) par_calc = ones_odd;
        else                     par_calc = ~ones_odd;
    end

    // Last tick count of the current bit or of the stop period.
    assign lim = (state == SQ_STOP) ? stop_last : BIT_LAST;

    // Frame sequencing and format capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SQ_IDLE;
            cnt       <= '0;
            idx       <= '0;
            last_idx  <= '0;
            stop_last <= '0;
            shreg     <= '0;
            par_on    <= 1'b0;
            par_bit   <= 1'b0;
        end else if (load_o) begin
            state    <= SQ_START;
            cnt      <= '0;
            idx      <= '0;
            shreg    <= hold_data_i;
            last_idx <= IW'(MIN_BITS - 1) + IW'(cfg_i.len);
            par_on   <= cfg_i.par_on;
            par_bit  <= par_calc;
            if (!cfg_i.stop_long)     stop_last <= CW'(STOP_ONE - 1);
            else if (cfg_i.len == '0) stop_last <= CW'(STOP_MID - 1);
            else                      stop_last <= CW'(STOP_TWO - 1);
        end else if (tick_i && state != SQ_IDLE) begin
            if (cnt == lim) begin
                cnt <= '0;
                case (state)
                    SQ_START: state <= SQ_DATA;
                    SQ_DATA: begin
                        shreg <= shreg >> 1;
                        if (idx == last_idx) state <= par_on ? SQ_PAR : SQ_STOP;
                        else                 idx   <= idx + 1'b1;
                    end
                    SQ_PAR:  state <= SQ_STOP;
                    default: state <= SQ_IDLE;
                endcase
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Line level for the current frame element.
    always_comb begin
        case (state)
            SQ_START: line_o = 1'b0;
            SQ_DATA:  line_o = shreg[0];
            SQ_PAR:   line_o = par_bit;
            default:  line_o = 1'b1;
        endcase
    end

    AST_CNT_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i) |=> ($stable(cnt) && $stable(state))); // R2
    AST_BIT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_STOP) |-> (cnt < CW'(OVS))); // R2
    AST_DATA_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_DATA) |-> (idx <= last_idx)); // R1
    AST_STOP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_STOP) |-> (cnt <= stop_last)); // R3

endmodule

// File: rtl/sertx_top.sv
// Configurable asynchronous serial transmitter: holding slot, frame
// sequencer and break override on the output line.
// Assumes the control inputs come from a register and baud_tick from a divider.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        len_sel,
    input  logic              stop_sel,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              par_stick,
    input  logic              brk,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_idle
);

    frame_cfg_t        cfg;
    logic [DATA_W-1:0] hold_data;
    logic              load;
    logic              line;
    logic              seq_idle;

    assign cfg = '{len: len_sel, stop_long: stop_sel, par_on: par_en,
                   par_even: par_even, par_stick: par_stick};

    sertx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .load_i(load), .hold_data(hold_data), .hold_empty(hold_empty)
    );

    sertx_seq #(.DATA_W(DATA_W), .OVS(OVS)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick_i(baud_tick), .hold_full_i(~hold_empty),
        .hold_data_i(hold_data), .cfg_i(cfg), .load_o(load), .line_o(line),
        .idle_o(seq_idle)
    );

    // Break forces a space on the line only; the sequencer keeps timing.
    assign txd     = brk ? 1'b0 : line;
    assign tx_idle = hold_empty & seq_idle;

    AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !tx_idle); // R8
    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle && !brk) |-> txd); // R9

endmodule

// File: tb/tb_sertx_top.sv
module tb_sertx_top;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [11:0] bits;
        int          nb;
        int          stop;
        string       tag;
    } exp_t;

    logic       clk = 0, rst_n = 0, baud_tick = 0, wr_en = 0;
    logic [7:0] wr_data = '0;
    logic [1:0] len_sel = 2'd3;
    logic       stop_sel = 0, par_en = 0, par_even = 0, par_stick = 0, brk = 0;
    logic       txd, hold_empty, tx_idle;

    int   checks = 0, failures = 0;
    bit   finished = 0;
    bit   mon_en = 0, in_frame = 0;
    event tick_ev;
    exp_t q[$];

    sertx_top dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .len_sel(len_sel), .stop_sel(stop_sel),
        .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
        .brk(brk), .txd(txd), .hold_empty(hold_empty), .tx_idle(tx_idle)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Tick generator: one-cycle pulse every 4 clocks, event after the sampled edge.
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            baud_tick = 1;
            @(negedge clk);
            baud_tick = 0;
            -> tick_ev;
        end
    end

    function automatic exp_t make_exp(input logic [7:0] d, input string tag);
        exp_t e;
        int   n;
        logic ones;
        n = 5 + int'(len_sel);
        e.bits = '0;
        ones = 0;
        for (int i = 0; i < n; i++) begin
            e.bits[1+i] = d[i];
            ones ^= d[i];
        end
        e.nb = 1 + n;
        if (par_en) begin
            e.bits[1+n] = par_stick ? ~par_even : (par_even ? ones : ~ones);
            e.nb++;
        end
        e.stop = !stop_sel ? 16 : (len_sel == 2'd0 ? 24 : 32);
        e.tag = tag;
        return e;
    endfunction

    task automatic write_sync(input logic [7:0] d);
        @(tick_ev);
        wr_en = 1;
        wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic send(input logic [7:0] d, input string tag);
        q.push_back(make_exp(d, tag));
        write_sync(d);
    endtask

    task automatic set_cfg(input logic [1:0] l, input logic s, input logic pe,
                           input logic pv, input logic ps);
        len_sel = l; stop_sel = s; par_en = pe; par_even = pv; par_stick = ps;
    endtask

    task automatic wait_done();
        while (q.size() != 0 || in_frame) @(negedge clk);
    endtask

    // Scoreboard monitor: pops an expected frame at each start bit, compares.
    exp_t        cur;
    int          idx;
    logic [11:0] got;

    task automatic start_frame();
        if (q.size() == 0) begin
            chk("R1 unexpected start bit", 0, 1, 0);
            in_frame = 0;
        end else begin
            cur = q.pop_front();
            in_frame = 1;
            idx = 0;
            got = '0;
        end
    endtask

    task automatic end_frame(input int at, input int want);
        logic [11:0] m;
        m = 12'((1 << cur.nb) - 1);
        chk({cur.tag, " frame bits"}, (got & m) == (cur.bits & m),
            int'(got & m), int'(cur.bits & m));
        chk({"R2 R3 ", cur.tag, " frame end tick"}, at == want, at, want);
    endtask

    initial begin
        forever begin
            @(tick_ev);
            if (!mon_en) begin
                in_frame = 0;
            end else if (!in_frame) begin
                if (txd == 0) start_frame();
            end else begin
                idx++;
                if (idx < 16 * cur.nb) begin
                    if (idx % 16 == 8) got[idx/16] = txd;
                end else if (tx_idle) begin
                    end_frame(idx, 16 * cur.nb + cur.stop);
                    in_frame = 0;
                end else if (txd == 0) begin
                    end_frame(idx, 16 * cur.nb + cur.stop + 1);
                    start_frame();
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int  n;
        bit  all_low;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R9 txd after reset", txd == 1, txd, 1);
        chk("R9 hold_empty after reset", hold_empty == 1, hold_empty, 1);
        chk("R9 tx_idle after reset", tx_idle == 1, tx_idle, 1);
        mon_en = 1;

        // R1: plain 8-bit and 5-bit frames, upper written bits dropped.
        set_cfg(2'd3, 0, 0, 0, 0); send(8'hA5, "R1"); wait_done();
        set_cfg(2'd0, 0, 0, 0, 0); send(8'hED, "R1"); wait_done();
        // R3: 5-bit with 1.5 stop bits, 8-bit with 2 stop bits.
        set_cfg(2'd0, 1, 0, 0, 0); send(8'hF3, "R3"); wait_done();
        set_cfg(2'd3, 1, 0, 0, 0); send(8'h3C, "R3"); wait_done();
        // R4: even and odd parity at several lengths.
        set_cfg(2'd2, 1, 1, 1, 0); send(8'h4B, "R4"); wait_done();
        set_cfg(2'd1, 0, 1, 0, 0); send(8'h2A, "R4"); wait_done();
        set_cfg(2'd3, 0, 1, 0, 0); send(8'h00, "R4"); wait_done();
        // R5: forced parity both senses.
        set_cfg(2'd3, 0, 1, 0, 1); send(8'h81, "R5"); wait_done();
        set_cfg(2'd3, 0, 1, 1, 1); send(8'h7E, "R5"); wait_done();

        // R8 / R7: back-to-back characters.
        set_cfg(2'd3, 0, 0, 0, 0);
        send(8'h55, "R8");
        @(tick_ev);
        chk("R7 hold_empty at load tick", hold_empty == 1, hold_empty, 1);
        send(8'h96, "R8");
        chk("R7 hold_empty after write", hold_empty == 0, hold_empty, 0);
        chk("R8 tx_idle low with slot full", tx_idle == 0, tx_idle, 0);
        wait_done();

        // R10: control change after load leaves the current frame intact.
        set_cfg(2'd3, 0, 0, 0, 0);
        send(8'hC3, "R10");
        @(tick_ev);
        set_cfg(2'd0, 1, 1, 1, 1);
        wait_done();
        set_cfg(2'd3, 0, 0, 0, 0);

        // R6: break holds the line low while the frame is still timed.
        mon_en = 0;
        repeat (10) @(negedge clk);
        set_cfg(2'd3, 0, 1, 0, 0);
        brk = 1;
        @(negedge clk);
        write_sync(8'h5A);
        chk("R7 hold_empty low after write", hold_empty == 0, hold_empty, 0);
        n = 0;
        all_low = 1;
        forever begin
            @(tick_ev);
            if (n == 0) chk("R7 hold_empty at load tick under break", hold_empty == 1, hold_empty, 1);
            if (txd != 0) all_low = 0;
            if (tx_idle || n > 400) break;
            n++;
        end
        chk("R6 txd low during break", all_low, all_low, 1);
        chk("R6 frame still timed under break", n == 176, n, 176);
        brk = 0;
        @(negedge clk);
        chk("R6 line returns after break", txd == 1, txd, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule